// File: doc/BRIEF.md
# Narrow-to-Wide Multiplexed Bus Exchanger

This block joins a 12-bit narrow port to a 24-bit wide port that is made of two 12-bit halves: a low half and a high half. Toward the wide side, each half has its own edge-triggered capture register with its own active-low clock enable. Two narrow words that arrive on consecutive clocks can therefore be gathered into one wide word. Toward the narrow side, each wide half goes through its own level-sensitive latch with an active-low latch enable. A half-select input then decides which latched half appears on the narrow port. The narrow-side path is combinational from the latch inputs, so it does not wait for a clock edge.

Each direction has its own active-low output enable. Three-state drive is shown as a data vector plus a drive flag. The data vectors always show the stored contents, and the flags say whether they are driven onto the bus. The registers and latches keep storing while their outputs are disabled. A synchronous active-high reset clears the registers. While reset is high it also clears the latches.

Top module: `bus_exchanger`

## Requirements
- R1: After reset, b_out reads all zeros and a_out reads all zeros for either half-select value, as long as both latch enables stay high.
- R2: On a rising clock edge with cken1_n low, a_in is stored into the low half, b_out[11:0], and is visible after that edge.
- R3: On a rising clock edge with cken2_n low, a_in is stored into the high half, b_out[23:12], and is visible after that edge.
- R4: A half whose clock enable is high keeps its value across any number of clock edges, whatever a_in does.
- R5: With both clock enables low at one edge, the same a_in is stored into both halves.
- R6: While a latch enable is low (le1_n for low half b_in[11:0], le2_n for high half b_in[23:12]), the latch follows its b_in half with no clock edge needed.
- R7: While a latch enable is high, its latch holds the last value and ignores its b_in half.
- R8: sel = 1 places the low-half latch (b_in[11:0]) on a_out, and sel = 0 places the high-half latch (b_in[23:12]) on a_out.
- R9: a_oe is 1 exactly when oea_n is 0, and oea_n has no effect on b_oe.
- R10: b_oe is 1 exactly when oeb_n is 0. It covers both halves together, and oeb_n has no effect on a_oe.
- R11: Register capture and latch transfer still take place while the matching output enable is high. The stored values appear once the output is enabled again.
- R12: Storing word X with only cken1_n low, and then word Y on the next edge with only cken2_n low, gives b_out = {Y, X}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock for the wide-side registers |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 12 | Narrow-port data toward the wide side |
| b_in | input | 24 | Wide-port data toward the narrow side, {high half, low half} |
| cken1_n | input | 1 | Active-low capture enable, low-half register |
| cken2_n | input | 1 | Active-low capture enable, high-half register |
| le1_n | input | 1 | Active-low transparency enable, low-half latch |
| le2_n | input | 1 | Active-low transparency enable, high-half latch |
| sel | input | 1 | Half select for the narrow port: 1 = low half, 0 = high half |
| oea_n | input | 1 | Active-low narrow-port drive enable |
| oeb_n | input | 1 | Active-low wide-port drive enable |
| a_out | output | 12 | Narrow-port data (selected latch) |
| a_oe | output | 1 | Narrow-port drive flag |
| b_out | output | 24 | Wide-port data {high register, low register} |
| b_oe | output | 1 | Wide-port drive flag |

## Verification
Each half is written on its own with distinct words. This exposes a swapped enable or a swapped half, and a pair written on back-to-back edges then checks the {Y, X} packing order. Idle edges with a changing a_in, and a joint write, tell holding apart from a shared enable. On the narrow side, b_in changes while the latch is open and again after it closes, which separates transparency from hold; both sel values are tried with different contents in the two latches. The drive flags are toggled one at a time while storage goes on underneath, and the bench resolves each bus to Z. This shows that only the drive is gated.

// File: rtl/bxc_pkg.sv
package bxc_pkg;

    // Default narrow-port width and number of wide-side halves.
    localparam int HALF_W_DEF = 12;
    localparam int NUM_HALVES = 2;

    // Half indices on the wide side.
    localparam int HALF_LO = 0;
    localparam int HALF_HI = 1;

    // Half-select coding for the narrow-side multiplexer.
    typedef enum logic {
        SEL_HI_HALF = 1'b0,
        SEL_LO_HALF = 1'b1
    } half_sel_e;

    // Active-low enable to active-high qualifier.
    function automatic logic active(input logic en_n);
        return ~en_n;
    endfunction

endpackage

// File: rtl/bxc_half_reg.sv
module bxc_half_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cken_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import bxc_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (active(cken_n)) begin
            q <= d;
        end
    end
endmodule

// File: rtl/bxc_half_latch.sv
module bxc_half_latch #(
    parameter int W = 12
) (
    input  logic         rst,
    input  logic         le_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import bxc_pkg::*;

    // Level-sensitive storage; reset level forces zero.
    always_latch begin
        if (rst) begin
            q <= '0;
        end else if (active(le_n)) begin
            q <= d;
        end
    end
endmodule

// File: rtl/bxc_half_mux.sv
module bxc_half_mux #(
    parameter int W = 12
) (
    input  logic         sel,
    input  logic [W-1:0] lo_q,
    input  logic [W-1:0] hi_q,
    output logic [W-1:0] y
);
    import bxc_pkg::*;

    half_sel_e sel_e;

    always_comb begin
        sel_e = half_sel_e'(sel);
        unique case (sel_e)
            SEL_LO_HALF: y = lo_q;
            SEL_HI_HALF: y = hi_q;
            default:     y = hi_q;
        endcase
    end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
    parameter int HALF_W = bxc_pkg::HALF_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [HALF_W-1:0]     a_in,
    input  logic [2*HALF_W-1:0]   b_in,
    input  logic                  cken1_n,
    input  logic                  cken2_n,
    input  logic                  le1_n,
    input  logic                  le2_n,
    input  logic                  sel,
    input  logic                  oea_n,
    input  logic                  oeb_n,
    output logic [HALF_W-1:0]     a_out,
    output logic                  a_oe,
    output logic [2*HALF_W-1:0]   b_out,
    output logic                  b_oe
);
    import bxc_pkg::*;

    localparam int NH     = NUM_HALVES;
    localparam int WIDE_W = NH * HALF_W;

    logic [NH-1:0]     cken_n_v;
    logic [NH-1:0]     le_n_v;
    logic [HALF_W-1:0] reg_q [NH];
    logic [HALF_W-1:0] lat_q [NH];
    logic [WIDE_W-1:0] wide_q;

    assign cken_n_v[HALF_LO] = cken1_n;
    assign cken_n_v[HALF_HI] = cken2_n;
    assign le_n_v[HALF_LO]   = le1_n;
    assign le_n_v[HALF_HI]   = le2_n;

    for (genvar g = 0; g < NH; g++) begin : g_half
        // Narrow-to-wide capture register for this half.
        bxc_half_reg #(.W(HALF_W)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .cken_n (cken_n_v[g]),
            .d      (a_in),
            .q      (reg_q[g])
        );

        // Wide-to-narrow transparent latch for this half.
        bxc_half_latch #(.W(HALF_W)) u_lat (
            .rst  (rst),
            .le_n (le_n_v[g]),
            .d    (b_in[g*HALF_W +: HALF_W]),
            .q    (lat_q[g])
        );

        assign wide_q[g*HALF_W +: HALF_W] = reg_q[g];
    end

    bxc_half_mux #(.W(HALF_W)) u_mux (
        .sel  (sel),
        .lo_q (lat_q[HALF_LO]),
        .hi_q (lat_q[HALF_HI]),
        .y    (a_out)
    );

    assign b_out = wide_q;
    assign a_oe  = active(oea_n);
    assign b_oe  = active(oeb_n);
endmodule

// File: rtl/bxc_checker.sv
module bxc_checker #(
    parameter int HALF_W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic [HALF_W-1:0]   a_in,
    input logic [2*HALF_W-1:0] b_in,
    input logic                cken1_n,
    input logic                cken2_n,
    input logic                le1_n,
    input logic                le2_n,
    input logic                sel,
    input logic                oea_n,
    input logic                oeb_n,
    input logic [HALF_W-1:0]   a_out,
    input logic                a_oe,
    input logic [2*HALF_W-1:0] b_out,
    input logic                b_oe
);
    localparam int W = HALF_W;

    // R2: low-half capture
    p_lo_capture_r2: assert property (@(posedge clk) disable iff (rst)
        !cken1_n |=> b_out[W-1:0] == $past(a_in));

    // R3: high-half capture
    p_hi_capture_r3: assert property (@(posedge clk) disable iff (rst)
        !cken2_n |=> b_out[2*W-1:W] == $past(a_in));

    // R4: hold when enable is high
    p_lo_hold_r4: assert property (@(posedge clk) disable iff (rst)
        cken1_n |=> $stable(b_out[W-1:0]));
    p_hi_hold_r4: assert property (@(posedge clk) disable iff (rst)
        cken2_n |=> $stable(b_out[2*W-1:W]));

    // R6 / R8: open latch routed to narrow port
    p_route_lo_r8: assert property (@(posedge clk) disable iff (rst)
        (!le1_n && sel) |-> a_out == b_in[W-1:0]);
    p_route_hi_r8: assert property (@(posedge clk) disable iff (rst)
        (!le2_n && !sel) |-> a_out == b_in[2*W-1:W]);

    // R9 / R10: drive flags follow their own enables only
    p_aoe_r9: assert property (@(posedge clk) disable iff (rst)
        a_oe != oea_n);
    p_boe_r10: assert property (@(posedge clk) disable iff (rst)
        b_oe != oeb_n);
endmodule

bind bus_exchanger bxc_checker #(.HALF_W(HALF_W)) chk_i (.*);

// File: tb/bus_exchanger_tb_top.sv
module bus_exchanger_tb_top;

    localparam int W = 12;

    typedef struct {
        string       req;
        logic [W-1:0]   a;
        logic [2*W-1:0] b;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0]   a_in = '0;
    logic [2*W-1:0] b_in = '0;
    logic cken1_n = 1'b1, cken2_n = 1'b1;
    logic le1_n = 1'b1, le2_n = 1'b1;
    logic sel = 1'b1, oea_n = 1'b0, oeb_n = 1'b0;
    logic [W-1:0]   a_out;
    logic           a_oe;
    logic [2*W-1:0] b_out;
    logic           b_oe;

    wire [W-1:0]   a_bus = a_oe ? a_out : {W{1'bz}};
    wire [2*W-1:0] b_bus = b_oe ? b_out : {2*W{1'bz}};

    // Bench model of stored contents
    logic [W-1:0] m_r1 = '0, m_r2 = '0, m_l1 = '0, m_l2 = '0;

    item_t sb[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_exchanger dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .cken1_n(cken1_n), .cken2_n(cken2_n), .le1_n(le1_n), .le2_n(le2_n),
        .sel(sel), .oea_n(oea_n), .oeb_n(oeb_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    // Driver side: expected value from the bench model
    task automatic push(input string req);
        item_t it;
        it.req = req;
        it.a = oea_n ? {W{1'bz}} : (sel ? m_l1 : m_l2);
        it.b = oeb_n ? {2*W{1'bz}} : {m_r2, m_r1};
        sb.push_back(it);
        #1;
    endtask

    task automatic clk_write(input logic [W-1:0] d, input logic c1, input logic c2);
        @(negedge clk);
        a_in = d; cken1_n = c1; cken2_n = c2;
        @(posedge clk);
        if (!c1) m_r1 = d;
        if (!c2) m_r2 = d;
        @(negedge clk);
        cken1_n = 1'b1; cken2_n = 1'b1;
        a_in = ~d;
        #1;
    endtask

    task automatic set_latch(input int half, input logic le_n, input logic [W-1:0] d);
        if (half == 0) begin
            le1_n = le_n; b_in[W-1:0] = d;
            if (!le_n) m_l1 = d;
        end else begin
            le2_n = le_n; b_in[2*W-1:W] = d;
            if (!le_n) m_l2 = d;
        end
        #1;
    endtask

    // Monitor side: pop and compare resolved buses
    initial begin
        forever begin
            item_t it;
            wait (sb.size() != 0);
            it = sb.pop_front();
            n_vec++;
            if (a_bus !== it.a || b_bus !== it.b) begin
                n_bad++;
                $display("FAIL %s: a=%h b=%h expected a=%h b=%h",
                         it.req, a_bus, b_bus, it.a, it.b);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        push("R1 reset sel=1");
        sel = 1'b0; push("R1 reset sel=0");
        sel = 1'b1;

        // R2 / R3 / R12: pack X then Y
        clk_write(12'hA5C, 1'b0, 1'b1); push("R2 low capture");
        clk_write(12'h3E1, 1'b1, 1'b0); push("R3 high capture, R12 {Y,X}");

        // R4: idle edges with changing a_in
        @(negedge clk) a_in = 12'hFFF;
        @(negedge clk) a_in = 12'h000;
        #1 push("R4 hold over idle edges");

        // R5: joint write
        clk_write(12'h777, 1'b0, 1'b0); push("R5 both halves");

        // R12: back-to-back pair
        @(negedge clk);
        a_in = 12'h123; cken1_n = 1'b0; cken2_n = 1'b1;
        @(posedge clk); m_r1 = 12'h123;
        @(negedge clk);
        a_in = 12'hFED; cken1_n = 1'b1; cken2_n = 1'b0;
        @(posedge clk); m_r2 = 12'hFED;
        @(negedge clk); cken2_n = 1'b1; #1;
        push("R12 consecutive pack");

        // R6: transparency, same cycle
        sel = 1'b1;
        set_latch(0, 1'b0, 12'h9AB); push("R6 transparent low");
        set_latch(0, 1'b0, 12'h456); push("R6 follows change");
        // R7: hold
        set_latch(0, 1'b1, 12'h000); push("R7 hold low latch");
        // R8: select
        set_latch(1, 1'b0, 12'hBCD);
        set_latch(1, 1'b1, 12'h111);
        sel = 1'b0; #1 push("R8 sel=0 high half, R7 hold");
        sel = 1'b1; #1 push("R8 sel=1 low half");

        // R9 / R10: drive flags independent
        oea_n = 1'b1; #1 push("R9 a disabled, b driven");
        oea_n = 1'b0; oeb_n = 1'b1; #1 push("R10 b disabled, a driven");

        // R11: storage continues while disabled
        oea_n = 1'b1;
        clk_write(12'h0F0, 1'b0, 1'b1);
        set_latch(0, 1'b0, 12'h321);
        set_latch(0, 1'b1, 12'hEEE);
        push("R11 both disabled");
        oea_n = 1'b0; oeb_n = 1'b0; #1 push("R11 stored while disabled");

        done = 1;
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule